// File: doc/BRIEF.md
# Fractional Predivider Clock Generator

This block makes a programmable clock, such as a pixel clock or an audio master clock, from one of three sources: a crystal reference and two PLL outputs. The chosen source is divided in two stages. A predivider divides by 2, 2.5 or 3. An integer divider then divides by a value from 2 to 127. The output frequency is therefore source / (predivide × divide). Software picks the divisor values. The block only applies the values it is given.

All logic runs on one core clock. Each source is given as a one-cycle tick per source edge. The output is a registered signal, so it cannot glitch. One write port carries the whole configuration word, and every write replaces every field. The new source, predivider and divider settings are held in a shadow register and take effect only when the current output period ends. The enable bit acts at once, but it only lets a high phase that has already started run to its end. When the source is crystal ticks every core cycle, all output phase lengths below are counted in core cycles.

Top module: `frac_clkgen`

## Requirements
- R1: Bit 10 of the configuration word selects the source. When it is 0 the source is tick input 0, and bit 9 has no effect. When it is 1, bit 9 chooses tick input 1 (value 0) or tick input 2 (value 1).
- R2: Bits 8:7 set the predivider. Code 1 divides the source by 2 and code 3 divides it by 3. The output period is predivide × divide source ticks.
- R3: Code 2 divides by 2.5. Predivided periods alternate between 2 and 3 source ticks, so any two consecutive output periods together last 5 × divide ticks.
- R4: Bits 6:0 hold the integer divider D. Each output period has a high phase of ceil(D/2) predivided periods followed by a low phase of floor(D/2) predivided periods. D = 2 and D = 127 both work.
- R5: Bit 11 is the enable, and it is separate from the divider fields. With valid fields and the enable at 0, the output stays low. Setting the enable starts the output.
- R6: If the predivider code is 0, or if D is below 2, the output is held low.
- R7: From idle, a valid write with the enable set that is sampled on edge k makes the output go high after edge k+2.
- R8: A write made while the output is running takes effect only at the end of the current output period. The current period finishes with the old settings.
- R9: Clearing the enable during a high phase lets that high phase finish at its full length. The output then stays low.
- R10: Every high phase lasts at least two core cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 3 | Source edge ticks: crystal, first PLL, second PLL |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 12 | Configuration word: enable, esel, psel, predivider code, divider |
| clk_o | output | 1 | Generated clock |

## Verification
Inputs change on falling edges and the output is sampled on falling edges, one core cycle at a time. From idle, the output is due high exactly two edges after the edge that samples the write, and the bench checks the three falling edges that follow that write. A reconfiguration only becomes visible after the period that is in progress ends. For that reason, rates are measured over whole periods, from one rising edge of the output to the next, after the transitional periods have been skipped. The update and disable checks, however, start counting at the rising edge during which the write is made. This lets them prove that the old high and low lengths are kept until the boundary.

// File: rtl/fclk_pkg.sv
package fclk_pkg;
  localparam int FC_DIV_W = 7;
  localparam int FC_N_SRC = 3;
  localparam int FC_CFG_W = FC_DIV_W + 5;
  localparam int FC_EN_BIT = FC_CFG_W - 1;

  typedef enum logic [1:0] {
    PRE_OFF = 2'd0,
    PRE_2   = 2'd1,
    PRE_25  = 2'd2,
    PRE_3   = 2'd3
  } pre_e;

  typedef struct packed {
    logic                esel;
    logic                psel;
    pre_e                pre;
    logic [FC_DIV_W-1:0] div;
  } fcfg_t;
endpackage

// File: rtl/fclk_src_mux.sv
module fclk_src_mux
  import fclk_pkg::*;
(
  input  logic [FC_N_SRC-1:0] tick_i,
  input  logic                esel_i,
  input  logic                psel_i,
  output logic                tick_o
);
  always_comb begin
    if (!esel_i)     tick_o = tick_i[0];
    else if (psel_i) tick_o = tick_i[2];
    else             tick_o = tick_i[1];
  end
endmodule

// File: rtl/fclk_prediv.sv
module fclk_prediv
  import fclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  pre_e pre_i,
  output logic pulse_o
);
  logic [1:0] cnt_q, lim;
  logic       alt_q;

  // 2.5 mode: periods of 2 and 3 ticks alternate
  always_comb begin
    lim = 2'd2;
    if (pre_i == PRE_3 || (pre_i == PRE_25 && alt_q)) lim = 2'd3;
    pulse_o = tick_i && (pre_i != PRE_OFF) && (cnt_q == lim - 2'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      alt_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      alt_q <= 1'b0;
    end else if (pulse_o) begin
      cnt_q <= '0;
      alt_q <= ~alt_q;
    end else if (tick_i && pre_i != PRE_OFF) begin
      cnt_q <= cnt_q + 2'd1;
    end
  end

  // R2
  pre_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= 2'd2);
endmodule

// File: rtl/fclk_divider.sv
module fclk_divider #(
  parameter int DIV_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             wrap_o,
  output logic             hi_next_o
);
  logic [DIV_W-1:0] cnt_q, cnt_nxt;
  logic [DIV_W:0]   hi_len;

  always_comb begin
    wrap_o = step_i && (cnt_q == div_i - {{(DIV_W-1){1'b0}}, 1'b1});
    if (clr_i)       cnt_nxt = '0;
    else if (wrap_o) cnt_nxt = '0;
    else if (step_i) cnt_nxt = cnt_q + {{(DIV_W-1){1'b0}}, 1'b1};
    else             cnt_nxt = cnt_q;
    // high for ceil(D/2) predivided periods
    hi_len    = ({1'b0, div_i} + {{DIV_W{1'b0}}, 1'b1}) >> 1;
    hi_next_o = {1'b0, cnt_nxt} < hi_len;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_nxt;
  end

  // R4
  div_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_i >= 2) |-> (cnt_q < div_i));
endmodule

// File: rtl/frac_clkgen.sv
module frac_clkgen
  import fclk_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [FC_N_SRC-1:0] src_tick_i,
  input  logic                cfg_we_i,
  input  logic [FC_CFG_W-1:0] cfg_wdata_i,
  output logic                clk_o
);
  fcfg_t pend_q, act_q;
  logic  pend_vld_q, en_q, stop_q, clk_q;
  logic  act_ok, pend_ok, go, go_new;
  logic  src_tick, pre_pulse, wrap, hi_next;
  logic  period_end, apply, clr;

  always_comb begin
    act_ok     = (act_q.pre != PRE_OFF) && (act_q.div >= 2);
    pend_ok    = (pend_q.pre != PRE_OFF) && (pend_q.div >= 2);
    go         = en_q && act_ok;
    go_new     = en_q && pend_ok;
    period_end = !stop_q && wrap;
    apply      = pend_vld_q && (stop_q || period_end);
    clr        = stop_q || apply;
  end

  fclk_src_mux u_mux (
    .tick_i (src_tick_i),
    .esel_i (act_q.esel),
    .psel_i (act_q.psel),
    .tick_o (src_tick)
  );

  fclk_prediv u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .tick_i  (src_tick),
    .pre_i   (act_q.pre),
    .pulse_o (pre_pulse)
  );

  fclk_divider #(.DIV_W(FC_DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .step_i    (pre_pulse),
    .div_i     (act_q.div),
    .wrap_o    (wrap),
    .hi_next_o (hi_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q       <= 1'b0;
      pend_q     <= '0;
      pend_vld_q <= 1'b0;
      act_q      <= '0;
      stop_q     <= 1'b1;
      clk_q      <= 1'b0;
    end else begin
      if (cfg_we_i) begin
        en_q       <= cfg_wdata_i[FC_EN_BIT];
        pend_q     <= fcfg_t'(cfg_wdata_i[FC_CFG_W-2:0]);
        pend_vld_q <= 1'b1;
      end else if (apply) begin
        pend_vld_q <= 1'b0;
      end
      if (apply) act_q <= pend_q;

      if (stop_q) begin
        if (!apply && go) begin
          stop_q <= 1'b0;
          clk_q  <= 1'b1;
        end
      end else if (apply) begin
        clk_q  <= go_new;
        stop_q <= !go_new;
      end else if (!en_q && (!clk_q || !hi_next)) begin
        // disabled: stop once the high phase is over
        clk_q  <= 1'b0;
        stop_q <= 1'b1;
      end else begin
        clk_q <= hi_next;
      end
    end
  end

  assign clk_o = clk_q;

  // R6
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_q && !act_ok) |=> !clk_q);
  // R8
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_q && !period_end) |=> $stable(act_q));
  // R9
  off_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !clk_q) |=> !clk_q);
  // R10
  high_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk_q) |=> clk_q);
endmodule

// File: tb/tb_frac_clkgen.sv
module tb_frac_clkgen;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  tick = 3'b111;
  logic        we = 1'b0;
  logic [11:0] wdata = '0;
  logic        clk_out;
  int          total = 0, bad = 0, cyc = 0;
  bit          done = 1'b0;

  frac_clkgen dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .src_tick_i  (tick),
    .cfg_we_i    (we),
    .cfg_wdata_i (wdata),
    .clk_o       (clk_out)
  );

  always #(CLK_P/2) clk = ~clk;

  // crystal every cycle, first PLL every 2nd, second PLL every 3rd
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      tick = {(cyc % 3) == 0, (cyc % 2) == 0, 1'b1};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input bit en, input bit es, input bit ps, input logic [1:0] pre,
                    input logic [6:0] div);
    @(negedge clk);
    we = 1'b1;
    wdata = {en, es, ps, pre, div};
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_rise(input string tag);
    bit prev = clk_out;
    bit ok = 1'b0;
    for (int n = 0; n < 4000 && !ok; n++) begin
      @(negedge clk);
      if (!prev && clk_out) ok = 1'b1;
      prev = clk_out;
    end
    if (!ok) chk(1'b0, tag, 0, 1);
  endtask

  // called at a falling edge with the output high, just after a rise
  task automatic meas(output int hi, output int per);
    int lo = 0;
    hi = 1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (clk_out) hi++; else break;
    end
    lo = 1;
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      if (!clk_out) lo++; else break;
    end
    per = hi + lo;
  endtask

  task automatic hold_low(input int n, input string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (clk_out) seen++;
    end
    chk(seen == 0, tag, seen, 0);
  endtask

  task automatic run_cfg(input bit es, input bit ps, input logic [1:0] pre,
                         input logic [6:0] div, input int ehi, input int eper,
                         input string tag);
    int hi, per;
    wr(1'b1, es, ps, pre, div);
    repeat (3) wait_rise(tag);
    meas(hi, per);
    chk(hi == ehi, tag, hi, ehi);
    chk(per == eper, tag, per, eper);
  endtask

  task automatic t_reset;
    hold_low(20, "R5 reset output low");
  endtask

  task automatic t_start;
    int hi, per;
    wr(1'b1, 1'b0, 1'b0, 2'd1, 7'd4);
    chk(clk_out == 1'b0, "R7 low after edge k", clk_out, 0);
    @(negedge clk);
    chk(clk_out == 1'b0, "R7 low after edge k+1", clk_out, 0);
    @(negedge clk);
    chk(clk_out == 1'b1, "R7 high after edge k+2", clk_out, 1);
    wait_rise("R2 rise");
    meas(hi, per);
    chk(hi == 4, "R2 /2 x4 high", hi, 4);
    chk(per == 8, "R2 /2 x4 period", per, 8);
  endtask

  task automatic t_div;
    run_cfg(1'b0, 1'b0, 2'd3, 7'd4, 6, 12, "R2 /3 x4");
    run_cfg(1'b0, 1'b0, 2'd1, 7'd5, 6, 10, "R4 odd divider 5");
    run_cfg(1'b0, 1'b0, 2'd1, 7'd2, 2, 4, "R4 divider 2");
    run_cfg(1'b0, 1'b0, 2'd1, 7'd127, 128, 254, "R4 divider 127");
  endtask

  task automatic t_frac;
    int h1, p1, h2, p2;
    run_cfg(1'b0, 1'b0, 2'd2, 7'd4, 5, 10, "R3 /2.5 x4");
    wr(1'b1, 1'b0, 1'b0, 2'd2, 7'd2);
    repeat (3) wait_rise("R3 rise");
    meas(h1, p1);
    chk(p1 == 5, "R3 /2.5 x2 period", p1, 5);
    chk(h1 >= 2, "R10 high at least two cycles", h1, 2);
    wr(1'b1, 1'b0, 1'b0, 2'd2, 7'd3);
    repeat (3) wait_rise("R3 rise");
    meas(h1, p1);
    meas(h2, p2);
    chk(p1 + p2 == 15, "R3 /2.5 x3 two periods", p1 + p2, 15);
  endtask

  task automatic t_src;
    run_cfg(1'b1, 1'b0, 2'd1, 7'd4, 8, 16, "R1 first PLL");
    run_cfg(1'b1, 1'b1, 2'd1, 7'd4, 12, 24, "R1 second PLL");
    run_cfg(1'b0, 1'b1, 2'd1, 7'd4, 4, 8, "R1 psel ignored without esel");
  endtask

  task automatic t_update;
    int hi, per;
    run_cfg(1'b0, 1'b0, 2'd1, 7'd4, 4, 8, "R8 base");
    wait_rise("R8 rise");
    we = 1'b1;
    wdata = {1'b1, 1'b0, 1'b0, 2'd1, 7'd8};
    fork
      begin @(negedge clk); we = 1'b0; end
    join_none
    meas(hi, per);
    chk(hi == 4, "R8 old high kept", hi, 4);
    chk(per == 8, "R8 old period kept", per, 8);
    meas(hi, per);
    chk(hi == 8, "R8 new high", hi, 8);
    chk(per == 16, "R8 new period", per, 16);
  endtask

  task automatic t_disable;
    int hi = 1;
    run_cfg(1'b0, 1'b0, 2'd3, 7'd4, 6, 12, "R9 base");
    wait_rise("R9 rise");
    we = 1'b1;
    wdata = {1'b0, 1'b0, 1'b0, 2'd3, 7'd4};
    fork
      begin @(negedge clk); we = 1'b0; end
    join_none
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      if (clk_out) hi++; else break;
    end
    chk(hi == 6, "R9 high phase completes", hi, 6);
    hold_low(200, "R9 stays low");
  endtask

  task automatic t_enable;
    int hi, per;
    wr(1'b0, 1'b0, 1'b0, 2'd1, 7'd4);
    hold_low(100, "R5 disabled valid fields");
    wr(1'b1, 1'b0, 1'b0, 2'd1, 7'd4);
    wait_rise("R5 enable starts");
    meas(hi, per);
    chk(per == 8, "R5 enabled period", per, 8);
  endtask

  task automatic t_invalid;
    wr(1'b1, 1'b0, 1'b0, 2'd0, 7'd4);
    repeat (20) @(negedge clk);
    hold_low(100, "R6 predivider code 0");
    wr(1'b1, 1'b0, 1'b0, 2'd1, 7'd1);
    hold_low(100, "R6 divider 1");
    wr(1'b1, 1'b0, 1'b0, 2'd2, 7'd0);
    hold_low(100, "R6 divider 0");
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start();
    t_div();
    t_frac();
    t_src();
    t_update();
    t_disable();
    t_enable();
    t_invalid();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule